// File: doc/BRIEF.md
# Configuration transaction control engine

This block runs configuration transactions started by software through three 32-bit registers on a simple register bus: a data register, a control register and a status register. Software loads the data register, then writes the control register with its start bit set. The control word holds a packed command: direction, controller index, function, site, stack position and device. One cycle after the start write, the engine decodes that command and carries it out against an internal table.

The table holds six main-site oscillator frequency entries and a parameterised number of daughter-site oscillator entries, both writable. It also holds read-only voltage readings. The engine can instead emit one-cycle shutdown or reboot request pulses. A command the engine cannot serve does not fault the bus. The transaction completes anyway and an error bit is raised in the status register. A successful read leaves its result in the data register.

Top module: `cfg_xact_engine`

## Requirements
- R1: The control register sits at byte offset 0xA4. It stores the written word with bit 31 (start) and bits 19:18 forced to zero, so those bits always read 0. A write with bit 31 clear only stores the word and starts nothing. The field layout is:
  - bit 30: direction, 1 for write and 0 for read
  - bits 29:26: controller index
  - bits 25:20: function
  - bits 17:16: site
  - bits 15:12: stack position
  - bits 11:0: device
- R2: The status register sits at 0xA8. A start write sampled at clock edge N executes at edge N+1. After edge N+1, status reads bit 0 = 1 (complete) and bit 1 = 1 if the command was unsupported, otherwise bit 1 = 0. A direct bus write to status stores only bits 1:0, and bits 31:2 always read 0.
- R3: A command is supported only if the controller index is 0, the position is 0 and the site is 0 (main) or 1 (daughter). Any other target sets the error bit.
- R4: Function 1 (oscillator) reads return the stored frequency. The main-site entries for devices 0 to 5 reset to 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. Daughter-site devices below DB_OSC_N return entries that reset from DB_OSC_INIT. Any other device is an error.
- R5: A function 1 write to a valid entry stores the current data register contents into that entry, and a later read returns it.
- R6: Function 2 (voltage) reads return 3300000 for main-site device 0 and the values in DB_VOLT_VAL for daughter-site devices below DB_VOLT_N. A function 2 write is an error.
- R7: A function 8 write to main-site device 0 drives halt_req high for one cycle, and a function 9 write to that target drives restart_req high for one cycle. Both pulses appear in the cycle after the execute edge. A read of either function is an error.
- R8: Writes of function 7 or 11 to main-site device 0 complete without error and change no state. Every function other than 1, 2, 7, 8, 9 and 11 is an error.
- R9: Only a successful read changes the data register. A failed read and any write leave it as it was.
- R10: After reset, the data, control and status registers read 0, no pulse is active, and both oscillator tables hold their reset values, including entries changed before the reset.
- R11: A start write accepted in the execute cycle of the previous command is taken as the next command. That command executes one cycle later and sees the table as updated by its predecessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| halt_req | output | 1 | Shutdown request pulse |
| restart_req | output | 1 | Reboot request pulse |

## Verification
The hardest case to reach from the ports is back-to-back commands, where a second start write lands in the exact cycle in which the first command executes. Only then does the second command read a table entry that its predecessor wrote one edge earlier. The bench drives two control writes on consecutive edges: an oscillator write followed by a read of the same entry. It checks that the read returns the freshly written value. The rest of the stimulus consists of sweeps over every function in both directions at both sites, and over every combination of controller index, position and site. The expected values come from an arithmetic model of the supported targets.

// File: rtl/cfg_xact_engine.sv
module cfg_xact_engine #(
  parameter int DB_OSC_N = 3,
  parameter int DB_VOLT_N = 2,
  parameter logic [DB_OSC_N*32-1:0] DB_OSC_INIT = {32'd60000000, 32'd50000000, 32'd45000000},
  parameter logic [DB_VOLT_N*32-1:0] DB_VOLT_VAL = {32'd1000000, 32'd900000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        halt_req,
  output logic        restart_req
);
  localparam logic [7:0]  A_DATA = 8'hA0;
  localparam logic [7:0]  A_CTRL = 8'hA4;
  localparam logic [7:0]  A_STAT = 8'hA8;
  localparam logic [31:0] CTRL_KEEP = 32'h7FF3_FFFF;
  localparam int          MAIN_N = 6;
  localparam logic [11:0] MAIN_LIM = 12'(MAIN_N);
  localparam logic [11:0] DOSC_LIM = 12'(DB_OSC_N);
  localparam logic [11:0] DVOLT_LIM = 12'(DB_VOLT_N);
  localparam logic [31:0] MAIN_VOLT = 32'd3300000;
  localparam logic [31:0] MAIN_RST [MAIN_N] =
    '{32'd50000000, 32'd23750000, 32'd24000000, 32'd24000000, 32'd24000000, 32'd24000000};

  logic [31:0] data_q, ctrl_q;
  logic [1:0]  stat_q;
  logic        busy_q;
  logic [31:0] mosc_q [MAIN_N];
  logic [31:0] dosc_q [DB_OSC_N];

  wire        f_wr   = ctrl_q[30];
  wire [3:0]  f_idx  = ctrl_q[29:26];
  wire [5:0]  f_fn   = ctrl_q[25:20];
  wire [1:0]  f_site = ctrl_q[17:16];
  wire [3:0]  f_pos  = ctrl_q[15:12];
  wire [11:0] f_dev  = ctrl_q[11:0];

  wire tgt_ok  = (f_idx == 4'd0) && (f_pos == 4'd0) && (f_site[1] == 1'b0);
  wire at_main = tgt_ok && (f_site == 2'd0);
  wire at_dght = tgt_ok && (f_site == 2'd1);
  wire main0   = at_main && (f_dev == 12'd0);
  wire m_osc   = at_main && (f_dev < MAIN_LIM);
  wire d_osc   = at_dght && (f_dev < DOSC_LIM);
  wire d_volt  = at_dght && (f_dev < DVOLT_LIM);
  wire is_osc  = (f_fn == 6'd1);
  wire is_volt = (f_fn == 6'd2);
  wire is_noop = (f_fn == 6'd7) || (f_fn == 6'd11);
  wire is_halt = (f_fn == 6'd8);
  wire is_boot = (f_fn == 6'd9);

  logic        rd_ok, wr_ok;
  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < MAIN_N; i++)
      if (m_osc && f_dev == 12'(i)) rd_val = mosc_q[i];
    for (int i = 0; i < DB_OSC_N; i++)
      if (d_osc && f_dev == 12'(i)) rd_val = dosc_q[i];
    if (is_volt) begin
      rd_val = main0 ? MAIN_VOLT : '0;
      for (int i = 0; i < DB_VOLT_N; i++)
        if (d_volt && f_dev == 12'(i)) rd_val = DB_VOLT_VAL[i*32 +: 32];
    end
  end

  assign rd_ok = (is_osc && (m_osc || d_osc)) || (is_volt && (main0 || d_volt));
  assign wr_ok = (is_osc && (m_osc || d_osc)) || (main0 && (is_noop || is_halt || is_boot));
  wire   ok    = f_wr ? wr_ok : rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q      <= '0;
      ctrl_q      <= '0;
      stat_q      <= '0;
      busy_q      <= 1'b0;
      halt_req    <= 1'b0;
      restart_req <= 1'b0;
      for (int i = 0; i < MAIN_N; i++) mosc_q[i] <= MAIN_RST[i];
      for (int i = 0; i < DB_OSC_N; i++) dosc_q[i] <= DB_OSC_INIT[i*32 +: 32];
    end else begin
      halt_req    <= busy_q && f_wr && main0 && is_halt;
      restart_req <= busy_q && f_wr && main0 && is_boot;
      busy_q      <= bus_wr && (bus_addr == A_CTRL) && bus_wdata[31];
      if (bus_wr) begin
        case (bus_addr)
          A_DATA:  data_q <= bus_wdata;
          A_CTRL:  ctrl_q <= bus_wdata & CTRL_KEEP;
          A_STAT:  stat_q <= bus_wdata[1:0];
          default: ;
        endcase
      end
      if (busy_q) begin
        stat_q <= {~ok, 1'b1};
        if (!f_wr && rd_ok) data_q <= rd_val;
        if (f_wr && is_osc) begin
          for (int i = 0; i < MAIN_N; i++)
            if (m_osc && f_dev == 12'(i)) mosc_q[i] <= data_q;
          for (int i = 0; i < DB_OSC_N; i++)
            if (d_osc && f_dev == 12'(i)) dosc_q[i] <= data_q;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_q;
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {30'd0, stat_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_xact_checker.sv
module cfg_xact_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        halt_req,
  input logic        restart_req,
  input logic [1:0]  stat_q,
  input logic        busy_q
);
  // R2: start write completes one edge after it is taken
  a_r2_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'hA4 && bus_wdata[31]) |=> ##1 stat_q[0]);

  // R2: direct status write stores bits 1:0 when no command executes
  a_r2_stat_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'hA8 && !busy_q) |=> stat_q == $past(bus_wdata[1:0]));

  // R1: start and bits 19:18 never read back
  a_r1_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'hA4) |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));

  // R7: a request pulse only follows an error-free completion
  a_r7_pulse_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || restart_req) |-> stat_q == 2'b01);

  // R7: shutdown and reboot never requested together
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && restart_req));
endmodule

bind cfg_xact_engine cfg_xact_checker u_chk (.*);

// File: tb/sim_cfg_xact_engine.sv
module sim_cfg_xact_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        halt_req, restart_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mm [6];
  logic [31:0] dm [3];
  logic [31:0] dv [2];

  cfg_xact_engine #(
    .DB_OSC_N(3), .DB_VOLT_N(2),
    .DB_OSC_INIT({32'd60000000, 32'd50000000, 32'd45000000}),
    .DB_VOLT_VAL({32'd1000000, 32'd900000})
  ) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    mm = '{32'd50000000, 32'd23750000, 32'd24000000, 32'd24000000, 32'd24000000, 32'd24000000};
    dm = '{32'd45000000, 32'd50000000, 32'd60000000};
    dv = '{32'd900000, 32'd1000000};
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic model(input bit w, input logic [3:0] idx, input logic [5:0] fn, input logic [1:0] site,
                       input logic [3:0] pos, input logic [11:0] dev, input logic [31:0] din,
                       output bit ok, output logic [31:0] val);
    ok = 0; val = din;
    if (idx == 0 && pos == 0 && site < 2) begin
      if (fn == 1) begin
        if (site == 0 && dev < 6) begin ok = 1; if (w) mm[dev] = din; else val = mm[dev]; end
        else if (site == 1 && dev < 3) begin ok = 1; if (w) dm[dev] = din; else val = dm[dev]; end
      end else if (fn == 2) begin
        if (!w && site == 0 && dev == 0) begin ok = 1; val = 32'd3300000; end
        else if (!w && site == 1 && dev < 2) begin ok = 1; val = dv[dev]; end
      end else if (w && site == 0 && dev == 0 && (fn == 7 || fn == 8 || fn == 9 || fn == 11)) ok = 1;
    end
  endtask

  // runs one command and compares status, data and pulses with the model
  task automatic run(input bit w, input logic [3:0] idx, input logic [5:0] fn, input logic [1:0] site,
                     input logic [3:0] pos, input logic [11:0] dev, input logic [31:0] din, input string tag);
    bit ok; logic [31:0] ev, st, dat; bit h, r, eh, er;
    wr(8'hA0, din);
    wr(8'hA8, 32'h0);
    model(w, idx, fn, site, pos, dev, din, ok, ev);
    wr(8'hA4, {1'b1, w, idx, fn, 2'b00, site, pos, dev});
    @(negedge clk);
    h = halt_req; r = restart_req;
    rd(8'hA8, st);
    rd(8'hA0, dat);
    chk(st == {30'd0, ~ok, 1'b1}, {tag, " status"}, st, {30'd0, ~ok, 1'b1});
    chk(dat == ev, {tag, " data"}, dat, ev);
    eh = w && ok && fn == 8; er = w && ok && fn == 9;
    chk(h == eh && r == er, {tag, " R7 pulses"}, {30'd0, h, r}, {30'd0, eh, er});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(8'hA0, v); chk(v == 0, "R10 data reset", v, 0);
    rd(8'hA4, v); chk(v == 0, "R10 ctrl reset", v, 0);
    rd(8'hA8, v); chk(v == 0, "R10 status reset", v, 0);
    chk(!halt_req && !restart_req, "R10 pulses idle", {30'd0, halt_req, restart_req}, 0);

    // R4 oscillator reset values, R6 voltages
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 8; d++)
        run(0, 0, 1, 2'(s), 0, 12'(d), 32'hDEAD0000 + 32'(d), "R4 osc read");
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 4; d++)
        run(0, 0, 2, 2'(s), 0, 12'(d), 32'h0BAD0000 + 32'(d), "R6 volt read");

    // R5 R7 R8 R9 every function, both directions, both sites
    for (int fn = 0; fn < 64; fn++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 2; s++)
          for (int d = 0; d < 2; d++)
            run(1'(w), 0, 6'(fn), 2'(s), 0, 12'(d),
                32'hA5000000 ^ (32'(fn) << 8) ^ (32'(w) << 4) ^ (32'(s) << 2) ^ 32'(d), "R8 R9 func sweep");

    // R3 every index, position and site
    for (int i = 0; i < 16; i++)
      for (int p = 0; p < 16; p++)
        for (int s = 0; s < 4; s++)
          run(0, 4'(i), 1, 2'(s), 4'(p), 0, 32'h33000000 + 32'(i * 64 + p * 4 + s), "R3 target");

    // R5 write then read back each entry
    for (int d = 0; d < 6; d++) begin
      run(1, 0, 1, 0, 0, 12'(d), 32'd1000 + 32'(d), "R5 main write");
      run(0, 0, 1, 0, 0, 12'(d), 32'hFFFF0000, "R5 main readback");
    end
    for (int d = 0; d < 3; d++) begin
      run(1, 0, 1, 1, 0, 12'(d), 32'd2000 + 32'(d), "R5 dght write");
      run(0, 0, 1, 1, 0, 12'(d), 32'hFFFF0000, "R5 dght readback");
    end

    // R1 control readback and no start without bit 31
    wr(8'hA8, 32'h0);
    wr(8'hA4, 32'h7FFF_FFFF);
    @(negedge clk); @(negedge clk);
    rd(8'hA4, v); chk(v == 32'h7FF3_FFFF, "R1 ctrl masked", v, 32'h7FF3_FFFF);
    rd(8'hA8, v); chk(v == 0, "R1 no start", v, 0);
    wr(8'hA4, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(8'hA4, v); chk(v == 32'h7FF3_FFFF, "R1 start reads zero", v, 32'h7FF3_FFFF);
    rd(8'hA8, v); chk(v == 32'h3, "R1 R3 start unsupported", v, 32'h3);

    // R2 direct status write
    wr(8'hA8, 32'hFFFF_FFFE);
    rd(8'hA8, v); chk(v == 32'h2, "R2 status bits", v, 32'h2);
    wr(8'hA8, 32'hFFFF_FFFD);
    rd(8'hA8, v); chk(v == 32'h1, "R2 status bits", v, 32'h1);

    // R11 back-to-back: write main dev 2, then read it in the next cycle
    wr(8'hA0, 32'h0BAC_0B0C);
    wr(8'hA8, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'hA4; bus_wdata = {1'b1, 1'b1, 4'd0, 6'd1, 2'b00, 2'd0, 4'd0, 12'd2};
    @(negedge clk);
    bus_wdata = {1'b1, 1'b0, 4'd0, 6'd1, 2'b00, 2'd0, 4'd0, 12'd2};
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    rd(8'hA0, v); chk(v == 32'h0BAC_0B0C, "R11 chained read", v, 32'h0BAC_0B0C);
    rd(8'hA8, v); chk(v == 32'h1, "R11 status", v, 32'h1);

    // R10 tables reload on reset
    run(1, 0, 1, 1, 0, 0, 32'h1234_5678, "R10 pre-reset write");
    run(1, 0, 1, 0, 0, 1, 32'h8765_4321, "R10 pre-reset write");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    run(0, 0, 1, 1, 0, 0, 32'h0, "R10 dght reload");
    run(0, 0, 1, 0, 0, 1, 32'h0, "R10 main reload");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule